// File: doc/BRIEF.md
# Runahead-Aware Set-Associative Tag Controller

This block holds the tags, line states and replacement order for a data cache that serves an in-order core which keeps running ahead while a miss is outstanding. Each cycle it may take one byte address and answer in that same cycle. The answer is one of four outcomes: hit, pending (the block is allocated but its refill has not arrived), miss, or retry. A miss picks its victim way and claims it at once. A fixed-latency countdown stands in for main memory, and a one-cycle refill event reports when each countdown ends.

A miss taken while the core runs normally switches the controller into runahead mode, with no cycles lost. The way that took that miss is then protected from replacement until its own refill lands, and that refill ends runahead mode. Misses taken during runahead allocate their own ways and their own entries in a small outstanding-miss table. When that table is full, or a set has no way that may be replaced, the controller answers retry and changes nothing.

Top module: `runahead_tag_store`

## Requirements
- R1: A request to a block whose refill has completed raises `resp_hit` in the request cycle, and `resp_way` gives the way holding it. The address offset bits (the low log2(BLOCK_BYTES) bits) take no part in the match. Exactly one of hit, pending, miss or retry is high for each valid request, and none of them is high while `req_valid` is low.
- R2: A request that matches no allocated block raises `resp_miss` in the same cycle and claims a way at once. Among the replaceable ways, the lowest-numbered empty way is used first. When no replaceable way is empty, the least recently used one is taken.
- R3: Replacement is true LRU within a set. A hit, a pending access and an allocation each make the accessed way the most recently used.
- R4: The refill for a miss requested in cycle k raises `fill_done` in cycle k+MISS_LAT, with `fill_set` and `fill_way` naming the line. Requests to that block up to and including that cycle report pending. From the next cycle on they report hit.
- R5: A miss taken while `runahead_active` is low drives `runahead_active` high from the next cycle. A cycle without such a miss leaves it low.
- R6: `runahead_active` falls in the cycle after the refill of the miss that started runahead. Misses taken during runahead, and refills of those misses, neither extend nor restart it.
- R7: While runahead is active, the way of the miss that started it is never chosen as a victim in its set. After runahead ends, that way becomes an ordinary LRU candidate again.
- R8: When the outstanding-miss table holds MT_DEPTH entries, or the set has no replaceable way, a non-matching request raises `resp_retry`. It allocates nothing, so a later request to that block is still a miss.
- R9: After reset no line is allocated, `runahead_active` is low and `fill_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_addr | input | ADDR_W | Byte address of the lookup |
| resp_hit | output | 1 | Block present and filled |
| resp_pending | output | 1 | Block allocated, refill outstanding |
| resp_miss | output | 1 | Block absent, way allocated now |
| resp_retry | output | 1 | Block absent, nothing allocated |
| resp_way | output | WAY_W | Way hit, or way allocated on a miss |
| fill_done | output | 1 | A refill completes this cycle |
| fill_set | output | SET_W | Set of the completing refill |
| fill_way | output | WAY_W | Way of the completing refill |
| runahead_active | output | 1 | Controller is in runahead mode |

## Verification
The assertions check the following on every cycle:
- the response outcomes are mutually exclusive;
- runahead mode starts only on a normal-mode miss;
- runahead mode lasts exactly MISS_LAT cycles and ends with a refill;
- the protected way is never handed out as a victim while runahead lasts.

Only the bench scenarios can show which way LRU picks after a given access history, the change from pending to hit at the refill boundary, the release of the protected way after exit, and the fact that a retried request leaves no allocation behind.

// File: rtl/rts_pkg.sv
package rts_pkg;
   typedef enum logic [1:0] {
      LN_EMPTY   = 2'd0,
      LN_PENDING = 2'd1,
      LN_FILLED  = 2'd2
   } line_state_e;
endpackage

// File: rtl/rts_lru_set.sv
module rts_lru_set #(
   parameter int WAYS  = 4,
   parameter int WAY_W = 2
) (
   input  logic [WAYS-1:0][WAY_W-1:0] age_i,
   input  logic [WAYS-1:0]            empty_i,
   input  logic [WAYS-1:0]            eligible_i,
   input  logic [WAY_W-1:0]           touch_way_i,
   output logic [WAY_W-1:0]           victim_o,
   output logic                       victim_ok_o,
   output logic [WAYS-1:0][WAY_W-1:0] age_o
);
   // age 0 is most recent; ages in a set always form a permutation
   logic             found_empty, found_any;
   logic [WAY_W-1:0] best_age;

   always_comb begin
      victim_o    = '0;
      found_empty = 1'b0;
      found_any   = 1'b0;
      best_age    = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (eligible_i[w] && empty_i[w] && !found_empty) begin
            victim_o    = WAY_W'(w);
            found_empty = 1'b1;
         end
      end
      if (!found_empty) begin
         for (int w = 0; w < WAYS; w++) begin
            if (eligible_i[w] && (!found_any || age_i[w] > best_age)) begin
               victim_o  = WAY_W'(w);
               best_age  = age_i[w];
               found_any = 1'b1;
            end
         end
      end
   end

   assign victim_ok_o = |eligible_i;

   generate
      if (WAYS == 1) begin : g_direct
         assign age_o[0] = '0;
      end else begin : g_assoc
         for (genvar gw = 0; gw < WAYS; gw++) begin : g_way
            assign age_o[gw] = (touch_way_i == WAY_W'(gw)) ? '0 :
                               (age_i[gw] < age_i[touch_way_i]) ? age_i[gw] + WAY_W'(1) :
                               age_i[gw];
         end
      end
   endgenerate
endmodule

// File: rtl/rts_miss_table.sv
module rts_miss_table #(
   parameter int DEPTH = 4,
   parameter int LAT   = 20,
   parameter int SET_W = 8,
   parameter int WAY_W = 2,
   parameter int TAG_W = 18,
   localparam int MI_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(LAT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_i,
   input  logic [SET_W-1:0] alloc_set_i,
   input  logic [WAY_W-1:0] alloc_way_i,
   input  logic [TAG_W-1:0] alloc_tag_i,
   output logic             full_o,
   output logic [MI_W-1:0]  alloc_idx_o,
   output logic             done_o,
   output logic [MI_W-1:0]  done_idx_o,
   output logic [SET_W-1:0] done_set_o,
   output logic [WAY_W-1:0] done_way_o,
   output logic [TAG_W-1:0] done_tag_o
);
   logic [DEPTH-1:0] vld_q;
   logic [CNT_W-1:0] cnt_q [DEPTH];
   logic [SET_W-1:0] set_q [DEPTH];
   logic [WAY_W-1:0] way_q [DEPTH];
   logic [TAG_W-1:0] tag_q [DEPTH];
   logic             free_found;

   always_comb begin
      alloc_idx_o = '0;
      free_found  = 1'b0;
      done_o      = 1'b0;
      done_idx_o  = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (!vld_q[i] && !free_found) begin
            alloc_idx_o = MI_W'(i);
            free_found  = 1'b1;
         end
         if (vld_q[i] && cnt_q[i] == '0 && !done_o) begin
            done_o     = 1'b1;
            done_idx_o = MI_W'(i);
         end
      end
   end

   assign full_o     = &vld_q;
   assign done_set_o = set_q[done_idx_o];
   assign done_way_o = way_q[done_idx_o];
   assign done_tag_o = tag_q[done_idx_o];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int i = 0; i < DEPTH; i++) cnt_q[i] <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (done_o && done_idx_o == MI_W'(i)) begin
               vld_q[i] <= 1'b0;
            end else if (vld_q[i] && cnt_q[i] != '0) begin
               cnt_q[i] <= cnt_q[i] - CNT_W'(1);
            end
            if (alloc_i && alloc_idx_o == MI_W'(i)) begin
               vld_q[i] <= 1'b1;
               cnt_q[i] <= CNT_W'(LAT - 1);
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (alloc_i && alloc_idx_o == MI_W'(i)) begin
            set_q[i] <= alloc_set_i;
            way_q[i] <= alloc_way_i;
            tag_q[i] <= alloc_tag_i;
         end
      end
   end
endmodule

// File: rtl/runahead_tag_store.sv
module runahead_tag_store
   import rts_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int CAPACITY    = 65536,
   parameter int BLOCK_BYTES = 64,
   parameter int WAYS        = 4,
   parameter int MISS_LAT    = 20,
   parameter int MT_DEPTH    = 4,
   localparam int SETS   = CAPACITY / (BLOCK_BYTES * WAYS),
   localparam int OFFS_W = $clog2(BLOCK_BYTES),
   localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1,
   localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
   localparam int TAG_W  = ADDR_W - SET_W - OFFS_W,
   localparam int MI_W   = (MT_DEPTH > 1) ? $clog2(MT_DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              resp_hit,
   output logic              resp_pending,
   output logic              resp_miss,
   output logic              resp_retry,
   output logic [WAY_W-1:0]  resp_way,
   output logic              fill_done,
   output logic [SET_W-1:0]  fill_set,
   output logic [WAY_W-1:0]  fill_way,
   output logic              runahead_active
);
   generate
      if ((1 << OFFS_W) != BLOCK_BYTES) begin : g_bad_block
         $error("BLOCK_BYTES must be a power of two");
      end
      if ((1 << WAY_W) != WAYS && WAYS != 1) begin : g_bad_ways
         $error("WAYS must be a power of two");
      end
      if (SETS * BLOCK_BYTES * WAYS != CAPACITY || (1 << SET_W) != SETS) begin : g_bad_cap
         $error("CAPACITY must give a power-of-two set count");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("ADDR_W too small for this geometry");
      end
      if (MISS_LAT < 1 || MT_DEPTH < 1) begin : g_bad_lat
         $error("MISS_LAT and MT_DEPTH must be at least 1");
      end
   endgenerate

   logic [TAG_W-1:0]            tag_q [SETS][WAYS];
   line_state_e                 st_q  [SETS][WAYS];
   logic [WAYS-1:0][WAY_W-1:0]  age_q [SETS];

   logic              ra_q;
   logic [SET_W-1:0]  pin_set_q;
   logic [WAY_W-1:0]  pin_way_q;
   logic [MI_W-1:0]   trig_idx_q;

   logic [SET_W-1:0]  req_set;
   logic [TAG_W-1:0]  req_tag;
   logic [WAYS-1:0]   empty_w, eligible_w, pin_mask;
   logic              hit_any, hit_filled, victim_ok, touch;
   logic [WAY_W-1:0]  hit_way, victim;
   logic [WAYS-1:0][WAY_W-1:0] age_next;

   logic              mt_full, mt_done;
   logic [MI_W-1:0]   mt_alloc_idx, mt_done_idx;
   logic [SET_W-1:0]  mt_done_set;
   logic [WAY_W-1:0]  mt_done_way;
   logic [TAG_W-1:0]  mt_done_tag;

   assign req_set = req_addr[OFFS_W +: SET_W];
   assign req_tag = req_addr[ADDR_W-1 -: TAG_W];

   always_comb begin
      empty_w = '0;
      hit_any = 1'b0;
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         empty_w[w] = (st_q[req_set][w] == LN_EMPTY);
         if (!empty_w[w] && tag_q[req_set][w] == req_tag && !hit_any) begin
            hit_any = 1'b1;
            hit_way = WAY_W'(w);
         end
      end
   end

   assign hit_filled = (st_q[req_set][hit_way] == LN_FILLED);
   assign pin_mask   = (ra_q && pin_set_q == req_set) ? (WAYS'(1) << pin_way_q) : '0;
   assign eligible_w = ~pin_mask;

   rts_lru_set #(.WAYS(WAYS), .WAY_W(WAY_W)) u_lru (
      .age_i       (age_q[req_set]),
      .empty_i     (empty_w),
      .eligible_i  (eligible_w),
      .touch_way_i (resp_way),
      .victim_o    (victim),
      .victim_ok_o (victim_ok),
      .age_o       (age_next)
   );

   rts_miss_table #(
      .DEPTH(MT_DEPTH), .LAT(MISS_LAT),
      .SET_W(SET_W), .WAY_W(WAY_W), .TAG_W(TAG_W)
   ) u_mt (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_i     (resp_miss),
      .alloc_set_i (req_set),
      .alloc_way_i (victim),
      .alloc_tag_i (req_tag),
      .full_o      (mt_full),
      .alloc_idx_o (mt_alloc_idx),
      .done_o      (mt_done),
      .done_idx_o  (mt_done_idx),
      .done_set_o  (mt_done_set),
      .done_way_o  (mt_done_way),
      .done_tag_o  (mt_done_tag)
   );

   assign resp_hit        = req_valid && hit_any && hit_filled;
   assign resp_pending    = req_valid && hit_any && !hit_filled;
   assign resp_miss       = req_valid && !hit_any && victim_ok && !mt_full;
   assign resp_retry      = req_valid && !hit_any && (!victim_ok || mt_full);
   assign resp_way        = hit_any ? hit_way : victim;
   assign touch           = resp_hit || resp_pending || resp_miss;
   assign fill_done       = mt_done;
   assign fill_set        = mt_done_set;
   assign fill_way        = mt_done_way;
   assign runahead_active = ra_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
               st_q[s][w]  <= LN_EMPTY;
               age_q[s][w] <= WAY_W'(w);
            end
         end
         ra_q       <= 1'b0;
         pin_set_q  <= '0;
         pin_way_q  <= '0;
         trig_idx_q <= '0;
      end else begin
         // a refill only lands if its line was not re-allocated meanwhile
         if (mt_done && st_q[mt_done_set][mt_done_way] == LN_PENDING &&
             tag_q[mt_done_set][mt_done_way] == mt_done_tag) begin
            st_q[mt_done_set][mt_done_way] <= LN_FILLED;
         end
         if (resp_miss) st_q[req_set][victim] <= LN_PENDING;
         if (touch)     age_q[req_set]        <= age_next;
         if (!ra_q && resp_miss) begin
            ra_q       <= 1'b1;
            pin_set_q  <= req_set;
            pin_way_q  <= victim;
            trig_idx_q <= mt_alloc_idx;
         end else if (ra_q && mt_done && mt_done_idx == trig_idx_q) begin
            ra_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (resp_miss) tag_q[req_set][victim] <= req_tag;
   end
endmodule

// File: rtl/runahead_tag_store_checker.sv
module runahead_tag_store_checker #(
   parameter int ADDR_W      = 32,
   parameter int CAPACITY    = 65536,
   parameter int BLOCK_BYTES = 64,
   parameter int WAYS        = 4,
   parameter int MISS_LAT    = 20,
   parameter int MT_DEPTH    = 4,
   localparam int SETS   = CAPACITY / (BLOCK_BYTES * WAYS),
   localparam int OFFS_W = $clog2(BLOCK_BYTES),
   localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1,
   localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              resp_hit,
   input logic              resp_pending,
   input logic              resp_miss,
   input logic              resp_retry,
   input logic [WAY_W-1:0]  resp_way,
   input logic              fill_done,
   input logic [SET_W-1:0]  fill_set,
   input logic [WAY_W-1:0]  fill_way,
   input logic              runahead_active
);
   logic [31:0]      ra_left;
   logic [SET_W-1:0] chk_pin_set, req_set;
   logic [WAY_W-1:0] chk_pin_way;

   assign req_set = req_addr[OFFS_W +: SET_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ra_left     <= '0;
         chk_pin_set <= '0;
         chk_pin_way <= '0;
      end else if (!runahead_active && resp_miss) begin
         ra_left     <= 32'(MISS_LAT - 1);
         chk_pin_set <= req_set;
         chk_pin_way <= resp_way;
      end else if (runahead_active && ra_left != 0) begin
         ra_left <= ra_left - 32'd1;
      end
   end

   assert_one_outcome_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> $onehot({resp_hit, resp_pending, resp_miss, resp_retry}));
   assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !(resp_hit || resp_pending || resp_miss || resp_retry));
   assert_enter_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!runahead_active && resp_miss) |=> runahead_active);
   assert_stay_normal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!runahead_active && !resp_miss) |=> !runahead_active);
   assert_fill_time_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (runahead_active && ra_left == 0) |-> fill_done);
   assert_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (runahead_active && ra_left == 0) |=> !runahead_active);
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (runahead_active && ra_left != 0) |=> runahead_active);
   assert_pin_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (runahead_active && resp_miss && req_set == chk_pin_set) |-> resp_way != chk_pin_way);
endmodule

bind runahead_tag_store runahead_tag_store_checker #(
   .ADDR_W(ADDR_W), .CAPACITY(CAPACITY), .BLOCK_BYTES(BLOCK_BYTES),
   .WAYS(WAYS), .MISS_LAT(MISS_LAT), .MT_DEPTH(MT_DEPTH)
) u_chk (.*);

// File: tb/runahead_tag_store_test.sv
module runahead_tag_store_test;
   localparam int LAT = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        resp_hit, resp_pending, resp_miss, resp_retry;
   logic [1:0]  resp_way;
   logic        fill_done;
   logic [7:0]  fill_set;
   logic [1:0]  fill_way;
   logic        runahead_active;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   logic [3:0] last_kind;
   logic [1:0] last_way;
   int         last_cyc;
   logic       last_ra, last_fd;
   logic [7:0] last_fs;
   logic [1:0] last_fw;

   localparam logic [3:0] K_HIT = 4'b1000, K_PEND = 4'b0100, K_MISS = 4'b0010, K_RETRY = 4'b0001;

   runahead_tag_store #(.MISS_LAT(LAT), .MT_DEPTH(4)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .resp_hit(resp_hit), .resp_pending(resp_pending), .resp_miss(resp_miss),
      .resp_retry(resp_retry), .resp_way(resp_way), .fill_done(fill_done),
      .fill_set(fill_set), .fill_way(fill_way), .runahead_active(runahead_active)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [31:0] blk(input int tag, input int set);
      return {14'(tag), 8'(set), 6'd0};
   endfunction

   task automatic check(input logic ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic issue(input logic [31:0] a);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      #1;
      last_kind = {resp_hit, resp_pending, resp_miss, resp_retry};
      last_way  = resp_way;
      last_cyc  = cyc;
      last_ra   = runahead_active;
      last_fd   = fill_done;
      last_fs   = fill_set;
      last_fw   = fill_way;
      @(posedge clk);
      #1 req_valid = 1'b0;
   endtask

   task automatic expect_resp(input logic [31:0] a, input logic [3:0] k, input int w, input string req);
      issue(a);
      check(last_kind == k, {req, " outcome"}, int'(last_kind), int'(k));
      if (k != K_RETRY) check(last_way == 2'(w), {req, " way"}, int'(last_way), w);
   endtask

   task automatic spin_to(input int target);
      wait (cyc == target);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      idle(2);
      #1;
      check(runahead_active == 1'b0, "R9 runahead after reset", int'(runahead_active), 0);
      check(fill_done == 1'b0, "R9 fill_done after reset", int'(fill_done), 0);
      check({resp_hit, resp_pending, resp_miss, resp_retry} == 4'b0, "R1 idle outcome",
            int'({resp_hit, resp_pending, resp_miss, resp_retry}), 0);
   endtask

   task automatic t_cold_miss();
      int k;
      expect_resp(blk(1, 0), K_MISS, 0, "R9 R2 cold miss");
      k = last_cyc;
      check(last_ra == 1'b0, "R5 normal before miss", int'(last_ra), 0);
      expect_resp(blk(1, 0), K_PEND, 0, "R4 pending after alloc");
      check(last_ra == 1'b1, "R5 runahead next cycle", int'(last_ra), 1);
      spin_to(k + LAT);
      expect_resp(blk(1, 0), K_PEND, 0, "R4 pending in fill cycle");
      check(last_fd == 1'b1 && last_fs == 8'd0 && last_fw == 2'd0, "R4 fill event",
            int'({last_fd, last_fs, last_fw}), 1024);
      check(last_ra == 1'b1, "R6 active in fill cycle", int'(last_ra), 1);
      expect_resp(blk(1, 0), K_HIT, 0, "R4 R1 hit after fill");
      check(last_ra == 1'b0, "R6 exit after trigger fill", int'(last_ra), 0);
   endtask

   task automatic t_fill_set();
      for (int t = 2; t <= 4; t++) begin
         expect_resp(blk(t, 0), K_MISS, t - 1, "R2 empty way first");
         idle(LAT + 2);
      end
      for (int t = 1; t <= 4; t++) expect_resp(blk(t, 0), K_HIT, t - 1, "R1 hit filled set");
   endtask

   task automatic t_lru();
      expect_resp(blk(1, 0), K_HIT, 0, "R3 touch way0");
      expect_resp(blk(5, 0), K_MISS, 1, "R3 LRU victim");
      idle(LAT + 2);
   endtask

   task automatic t_pin();
      int kf, kg;
      expect_resp(blk(6, 0), K_MISS, 2, "R3 trigger victim");
      kf = last_cyc;
      expect_resp(blk(4, 0), K_HIT, 3, "R3 touch way3");
      expect_resp(blk(1, 0), K_HIT, 0, "R3 touch way0");
      expect_resp(blk(5, 0), K_HIT, 1, "R3 touch way1");
      expect_resp(blk(7, 0), K_MISS, 3, "R7 pinned way skipped");
      kg = last_cyc;
      check(last_ra == 1'b1, "R6 active during runahead miss", int'(last_ra), 1);
      expect_resp(blk(1, 0), K_HIT, 0, "R1 hit during runahead");
      check(last_ra == 1'b1, "R6 not ended by runahead miss", int'(last_ra), 1);
      spin_to(kf + LAT + 1);
      expect_resp(blk(1, 0), K_HIT, 0, "R1 hit at exit");
      check(last_ra == 1'b0, "R6 exit on trigger fill", int'(last_ra), 0);
      spin_to(kg + LAT + 1);
      expect_resp(blk(5, 0), K_HIT, 1, "R1 hit");
      check(last_ra == 1'b0, "R6 later fill does not restart", int'(last_ra), 0);
      expect_resp(blk(7, 0), K_HIT, 3, "R4 runahead miss filled");
      expect_resp(blk(8, 0), K_MISS, 2, "R7 pin released after exit");
      idle(LAT + 2);
   endtask

   task automatic t_table_full();
      for (int s = 5; s <= 8; s++) expect_resp(blk(1, s), K_MISS, 0, "R8 fill table");
      expect_resp(blk(1, 9), K_RETRY, 0, "R8 retry when full");
      check(last_ra == 1'b1, "R6 still active", int'(last_ra), 1);
      expect_resp(blk(1, 9), K_RETRY, 0, "R8 retry again");
      idle(LAT + 2);
      expect_resp(blk(1, 6), K_HIT, 0, "R4 runahead fill hit");
      expect_resp(blk(1, 9), K_MISS, 0, "R8 retry left no allocation");
      idle(LAT + 2);
   endtask

   task automatic t_offset();
      expect_resp(blk(1, 0) | 32'h3F, K_HIT, 0, "R1 offset ignored");
      expect_resp(blk(1, 3), K_MISS, 0, "R2 other set misses");
      idle(LAT + 2);
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
   end

   initial begin
      idle(3);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_cold_miss();
      t_fill_set();
      t_lru();
      t_pin();
      t_table_full();
      t_offset();
      finish_run();
   end
endmodule